// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Invalidate Commands

This block caches address translations in a small, fully associative array. A lookup presents a virtual address and a context tag. In the same cycle it returns a hit flag, the index of the entry that hit, the translated physical address, and that entry's attributes: domain number, permission bits, execute-never, non-cacheable and security-state flags. Each entry holds a virtual page number, a page-size shift (the page covers `2**shift` bytes), a physical frame number, an address-space tag, a valid flag and those attributes.

New translations are written through an insert port. The insert always lands on the slot named by a single round-robin victim pointer. That pointer also steps past a slot whenever a lookup hits the slot it currently names, so an entry that was just used is not evicted next.

A three-bit command input removes entries in one cycle. It can clear everything, clear by tag, clear by address, or clear by address and tag together. Page-table walking, memory-attribute handling and event counting are left to the surrounding logic.

Top module: `tlb_fa`

## Requirements
- R1: An entry matches a lookup only when it is valid, its tag equals `lk_ctx`, and `lk_va >> shift` equals its page number. `lk_hit` is high only when `lk_en` is high and at least one entry matches.
- R2: When several entries match, `lk_idx` and all returned fields come from the matching entry with the lowest index.
- R3: `lk_pa` is the winning entry's frame number shifted left by its shift value, OR-ed with the low `shift` bits of `lk_va`.
- R4: A granted insert writes the slot named by the victim pointer, whether or not that slot is valid, and advances the pointer by one. The pointer wraps from N-1 to 0. The entry can be looked up from the next cycle on.
- R5: A lookup with `lk_en` high that hits the slot named by the victim pointer advances the pointer by one. When this coincides with an insert, the pointer advances only once.
- R6: Command code 1 clears every valid flag and returns the victim pointer to slot 0.
- R7: Command code 2 clears every entry whose tag equals `inv_asid`, whatever its address.
- R8: Command code 3 clears every entry whose page contains `inv_va` (`inv_va >> shift` equals the page number), whatever its tag.
- R9: Command code 4 clears every entry that a lookup of `inv_va` with context `inv_asid` would hit, including matches after the first. Entries with the same address and a different tag survive.
- R10: A command takes effect at the next clock edge. A lookup in the same cycle sees the state from before the command. An insert presented together with a command of code 1 to 4 is discarded. Codes 0 and 5 to 7 do nothing.
- R11: When `lk_hit` is low, `lk_idx`, `lk_pa` and every attribute output are zero. After reset no entry is valid and the pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| lk_en | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_ctx | input | ASID_W | Lookup context tag |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the winning entry |
| lk_pa | output | PA_W | Translated physical address |
| lk_dom | output | DOM_W | Domain of the winning entry |
| lk_perm | output | PERM_W | Permission bits of the winning entry |
| lk_xn | output | 1 | Execute-never flag |
| lk_nc | output | 1 | Non-cacheable flag |
| lk_ns | output | 1 | Security-state flag |
| wr_en | input | 1 | Insert request |
| wr_vpn | input | VA_W | Virtual page number (address shifted right by `wr_shift`) |
| wr_shift | input | SHIFT_W | Page-size shift |
| wr_pfn | input | PA_W | Physical frame number |
| wr_asid | input | ASID_W | Tag of the new entry |
| wr_dom | input | DOM_W | Domain of the new entry |
| wr_perm | input | PERM_W | Permission bits of the new entry |
| wr_xn | input | 1 | Execute-never flag of the new entry |
| wr_nc | input | 1 | Non-cacheable flag of the new entry |
| wr_ns | input | 1 | Security-state flag of the new entry |
| inv_cmd | input | 3 | Command: 0 none, 1 all, 2 by tag, 3 by address, 4 by address and tag, 5-7 none |
| inv_va | input | VA_W | Address operand for codes 3 and 4 |
| inv_asid | input | ASID_W | Tag operand for codes 2 and 4 |

## Verification
The properties assume that every inserted page has a shift of at least `MIN_SHIFT` (12), so the low twelve address bits always pass straight through. They also assume that `wr_vpn` is consistent with its shift, meaning the caller has already shifted the address. The bench only inserts pages with a shift of 12 or 16 and computes `wr_vpn` from an address shifted by that amount. The bench deliberately overlaps inserts, lookups and commands in the same cycle, including the unused command codes, so that the precedence rules are exercised rather than avoided.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  parameter int VA_W    = 32;
  parameter int PA_W    = 32;
  parameter int ASID_W  = 8;
  parameter int SHIFT_W = 5;
  parameter int DOM_W   = 4;
  parameter int PERM_W  = 3;

  typedef enum logic [2:0] {
    INV_NONE      = 3'd0,
    INV_ALL       = 3'd1,
    INV_ASID      = 3'd2,
    INV_ADDR      = 3'd3,
    INV_ADDR_ASID = 3'd4
  } inv_op_e;

  typedef struct packed {
    logic [VA_W-1:0]    vpn;
    logic [SHIFT_W-1:0] shift;
    logic [PA_W-1:0]    pfn;
    logic [ASID_W-1:0]  asid;
    logic [DOM_W-1:0]   dom;
    logic [PERM_W-1:0]  perm;
    logic               xn;
    logic               nc;
    logic               ns;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_fa_cmp.sv
// Per-slot comparators: lookup match and the operand matches for commands.
module tlb_fa_cmp
  import tlb_fa_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic              valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_ctx,
  input  logic [VA_W-1:0]   inv_va,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              lk_match,
  output logic              addr_hit,
  output logic              asid_hit
);
  always_comb begin
    lk_match = valid && (ent.asid == lk_ctx) && ((lk_va >> ent.shift) == ent.vpn);
    addr_hit = ((inv_va >> ent.shift) == ent.vpn);
    asid_hit = (ent.asid == inv_asid);
  end
endmodule

// File: rtl/tlb_fa_pick.sv
// Lowest-index-wins selector.
module tlb_fa_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fa_victim.sv
// Round-robin replacement pointer with wrap and clear.
module tlb_fa_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = clear | step;
    if (clear)                        ptr_d = '0;
    else if (ptr_q == IDX_W'(N - 1))  ptr_d = '0;
    else                              ptr_d = ptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_en,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [ASID_W-1:0]  lk_ctx,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [PA_W-1:0]    lk_pa,
  output logic [DOM_W-1:0]   lk_dom,
  output logic [PERM_W-1:0]  lk_perm,
  output logic               lk_xn,
  output logic               lk_nc,
  output logic               lk_ns,
  input  logic               wr_en,
  input  logic [VA_W-1:0]    wr_vpn,
  input  logic [SHIFT_W-1:0] wr_shift,
  input  logic [PA_W-1:0]    wr_pfn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [DOM_W-1:0]   wr_dom,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic               wr_xn,
  input  logic               wr_nc,
  input  logic               wr_ns,
  input  logic [2:0]         inv_cmd,
  input  logic [VA_W-1:0]    inv_va,
  input  logic [ASID_W-1:0]  inv_asid
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_n_s} <= 2'b00;
    else        {rst_meta, rst_n_s} <= {1'b1, rst_meta};
  end

  tlb_ent_t         ent_q [N];
  logic [N-1:0]     val_q, val_d;
  logic [N-1:0]     lk_m, ia_m, is_m, clr, wr_sel;
  logic             any_m;
  logic [IDX_W-1:0] sel_idx, victim;
  tlb_ent_t         sel, wr_ent;
  inv_op_e          op;
  logic             ins_go, hit_step;
  logic [VA_W-1:0]  off_mask;

  for (genvar g = 0; g < N; g++) begin : g_slot
    tlb_fa_cmp u_cmp (
      .ent      (ent_q[g]),
      .valid    (val_q[g]),
      .lk_va    (lk_va),
      .lk_ctx   (lk_ctx),
      .inv_va   (inv_va),
      .inv_asid (inv_asid),
      .lk_match (lk_m[g]),
      .addr_hit (ia_m[g]),
      .asid_hit (is_m[g])
    );

    assign wr_sel[g] = ins_go && (victim == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (wr_sel[g]) ent_q[g] <= wr_ent;
    end
  end

  tlb_fa_pick #(.N(N)) u_pick (.req(lk_m), .any(any_m), .idx(sel_idx));

  // lookup result
  always_comb begin
    lk_hit   = lk_en & any_m;
    sel      = ent_q[sel_idx];
    off_mask = ~({VA_W{1'b1}} << sel.shift);
    if (lk_hit) begin
      lk_idx  = sel_idx;
      lk_pa   = (sel.pfn << sel.shift) | PA_W'(lk_va & off_mask);
      lk_dom  = sel.dom;
      lk_perm = sel.perm;
      lk_xn   = sel.xn;
      lk_nc   = sel.nc;
      lk_ns   = sel.ns;
    end else begin
      lk_idx  = '0;
      lk_pa   = '0;
      lk_dom  = '0;
      lk_perm = '0;
      lk_xn   = 1'b0;
      lk_nc   = 1'b0;
      lk_ns   = 1'b0;
    end
  end

  // command decode and valid-flag next state
  always_comb begin
    case (inv_cmd)
      3'd1:    op = INV_ALL;
      3'd2:    op = INV_ASID;
      3'd3:    op = INV_ADDR;
      3'd4:    op = INV_ADDR_ASID;
      default: op = INV_NONE;
    endcase
    case (op)
      INV_ALL:       clr = '1;
      INV_ASID:      clr = is_m;
      INV_ADDR:      clr = ia_m;
      INV_ADDR_ASID: clr = ia_m & is_m;
      default:       clr = '0;
    endcase
    ins_go   = wr_en && (op == INV_NONE);
    hit_step = lk_hit && (sel_idx == victim);
    val_d    = (val_q & ~clr) | wr_sel;
    wr_ent   = '{vpn: wr_vpn, shift: wr_shift, pfn: wr_pfn, asid: wr_asid,
                 dom: wr_dom, perm: wr_perm, xn: wr_xn, nc: wr_nc, ns: wr_ns};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) val_q <= '0;
    else          val_q <= val_d;
  end

  tlb_fa_victim #(.N(N)) u_victim (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clear (op == INV_ALL),
    .step  (ins_go | hit_step),
    .ptr   (victim)
  );
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
  import tlb_fa_pkg::*;
#(
  parameter int N = 8,
  parameter int MIN_SHIFT = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_en,
  input logic [VA_W-1:0]    lk_va,
  input logic [ASID_W-1:0]  lk_ctx,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_pa,
  input logic               wr_en,
  input logic [VA_W-1:0]    wr_vpn,
  input logic [SHIFT_W-1:0] wr_shift,
  input logic [ASID_W-1:0]  wr_asid,
  input logic [2:0]         inv_cmd,
  input logic [VA_W-1:0]    inv_va,
  input logic [ASID_W-1:0]  inv_asid,
  input logic [IDX_W-1:0]   victim
);
  p_hit_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_en);

  p_pa_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[MIN_SHIFT-1:0] == lk_va[MIN_SHIFT-1:0]));

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    victim <= IDX_W'(N - 1));

  p_ins_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inv_cmd == 3'd0) |=>
      (victim == (($past(victim) == IDX_W'(N - 1)) ? '0 : $past(victim) + IDX_W'(1))));

  p_ins_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inv_cmd == 3'd0) |=>
      ((lk_en && lk_ctx == $past(wr_asid) && ((lk_va >> $past(wr_shift)) == $past(wr_vpn))) -> lk_hit));

  p_inv_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_cmd == 3'd1) |=> (victim == '0 && !lk_hit));

  p_inv_asid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_cmd == 3'd2) |=> !(lk_hit && lk_ctx == $past(inv_asid)));

  p_inv_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_cmd == 3'd3) |=> !(lk_hit && lk_va == $past(inv_va)));

  p_inv_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_cmd == 3'd4) |=> !(lk_hit && lk_va == $past(inv_va) && lk_ctx == $past(inv_asid)));
endmodule

bind tlb_fa tlb_fa_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .lk_en    (lk_en),
  .lk_va    (lk_va),
  .lk_ctx   (lk_ctx),
  .lk_hit   (lk_hit),
  .lk_pa    (lk_pa),
  .wr_en    (wr_en),
  .wr_vpn   (wr_vpn),
  .wr_shift (wr_shift),
  .wr_asid  (wr_asid),
  .inv_cmd  (inv_cmd),
  .inv_va   (inv_va),
  .inv_asid (inv_asid),
  .victim   (victim)
);

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
  import tlb_fa_pkg::*;
  localparam int N = 8;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic lk_en; logic [VA_W-1:0] lk_va; logic [ASID_W-1:0] lk_ctx;
  logic lk_hit; logic [IDX_W-1:0] lk_idx; logic [PA_W-1:0] lk_pa;
  logic [DOM_W-1:0] lk_dom; logic [PERM_W-1:0] lk_perm; logic lk_xn, lk_nc, lk_ns;
  logic wr_en; logic [VA_W-1:0] wr_vpn; logic [SHIFT_W-1:0] wr_shift;
  logic [PA_W-1:0] wr_pfn; logic [ASID_W-1:0] wr_asid; logic [DOM_W-1:0] wr_dom;
  logic [PERM_W-1:0] wr_perm; logic wr_xn, wr_nc, wr_ns;
  logic [2:0] inv_cmd; logic [VA_W-1:0] inv_va; logic [ASID_W-1:0] inv_asid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_fa #(.N(N)) uut (.*);

  // behavioural reference state
  bit              m_v    [N];
  logic [VA_W-1:0] m_vpn  [N];
  int              m_sh   [N];
  logic [PA_W-1:0] m_pfn  [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [DOM_W-1:0]  m_dom  [N];
  logic [PERM_W-1:0] m_perm [N];
  bit m_xn [N], m_nc [N], m_ns [N];
  int m_ptr = 0;

  function automatic int m_find(logic [VA_W-1:0] va, logic [ASID_W-1:0] ctx);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_asid[i] == ctx && (va >> m_sh[i]) == m_vpn[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag);
    int k = m_find(lk_va, lk_ctx);
    logic [63:0] exp_v, act_v;
    logic [PA_W-1:0] epa;
    exp_v = '0;
    if (lk_en && k >= 0) begin
      epa = (m_pfn[k] << m_sh[k]) | (lk_va & ~({VA_W{1'b1}} << m_sh[k]));
      exp_v = {1'b1, IDX_W'(k), epa, m_dom[k], m_perm[k], m_xn[k], m_nc[k], m_ns[k]};
    end
    act_v = {1'b0, lk_hit, lk_idx, lk_pa, lk_dom, lk_perm, lk_xn, lk_nc, lk_ns};
    exp_v = {1'b0, exp_v[62:0]};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: lookup va=%h ctx=%0d actual=%h expected=%h", tag, lk_va, lk_ctx, act_v, exp_v);
    end
  endtask

  task automatic m_update();
    int k = m_find(lk_va, lk_ctx);
    bit lh = lk_en && (k >= 0);
    bit act = (inv_cmd >= 3'd1 && inv_cmd <= 3'd4);
    bit step = 0;
    for (int i = 0; i < N; i++) begin
      case (inv_cmd)
        3'd1: m_v[i] = 0;
        3'd2: if (m_asid[i] == inv_asid) m_v[i] = 0;
        3'd3: if ((inv_va >> m_sh[i]) == m_vpn[i]) m_v[i] = 0;
        3'd4: if (m_asid[i] == inv_asid && (inv_va >> m_sh[i]) == m_vpn[i]) m_v[i] = 0;
        default: ;
      endcase
    end
    if (!act && wr_en) begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = wr_vpn; m_sh[m_ptr] = int'(wr_shift);
      m_pfn[m_ptr] = wr_pfn; m_asid[m_ptr] = wr_asid; m_dom[m_ptr] = wr_dom;
      m_perm[m_ptr] = wr_perm; m_xn[m_ptr] = wr_xn; m_nc[m_ptr] = wr_nc; m_ns[m_ptr] = wr_ns;
      step = 1;
    end
    if (lh && k == m_ptr) step = 1;
    if (inv_cmd == 3'd1) m_ptr = 0;
    else if (step) m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic idle_in();
    lk_en = 0; lk_va = '0; lk_ctx = '0; wr_en = 0; wr_vpn = '0; wr_shift = 5'd12;
    wr_pfn = '0; wr_asid = '0; wr_dom = '0; wr_perm = '0; wr_xn = 0; wr_nc = 0; wr_ns = 0;
    inv_cmd = 3'd0; inv_va = '0; inv_asid = '0;
  endtask

  // one cycle: inputs already set at the falling edge
  task automatic cyc(string tag);
    #1 check(tag);
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic set_ins(logic [VA_W-1:0] va, int sh, logic [PA_W-1:0] pfn, logic [ASID_W-1:0] a);
    wr_en = 1; wr_shift = SHIFT_W'(sh); wr_vpn = va >> sh; wr_pfn = pfn; wr_asid = a;
    wr_dom = DOM_W'(pfn[3:0] ^ a[3:0]); wr_perm = PERM_W'(pfn[2:0]);
    wr_xn = pfn[0]; wr_nc = pfn[1]; wr_ns = a[0];
  endtask

  task automatic ins(logic [VA_W-1:0] va, int sh, logic [PA_W-1:0] pfn, logic [ASID_W-1:0] a, string tag);
    idle_in(); set_ins(va, sh, pfn, a); cyc(tag);
  endtask

  task automatic lk(logic [VA_W-1:0] va, logic [ASID_W-1:0] c, string tag);
    idle_in(); lk_en = 1; lk_va = va; lk_ctx = c; cyc(tag);
  endtask

  task automatic inv(logic [2:0] cmd, logic [VA_W-1:0] va, logic [ASID_W-1:0] a, string tag);
    idle_in(); inv_cmd = cmd; inv_va = va; inv_asid = a; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc("R11");
    // R11: reset state, lookup of anything misses
    lk(32'h1000_0abc, 8'd1, "R11");
    lk(32'h0, 8'd0, "R11");

    // R4: fill every slot, then one more wraps onto slot 0
    for (int i = 0; i < N; i++)
      ins(32'h1000_0000 + i * 32'h1000, 12, 32'h8_0000 + i, 8'(i % 2 + 1), "R4");
    // R1/R3: hits with the right tag, misses with the wrong tag
    for (int i = 1; i < N; i++) begin
      lk(32'h1000_0abc + i * 32'h1000, 8'(i % 2 + 1), "R3");
      lk(32'h1000_0abc + i * 32'h1000, 8'(2 - i % 2), "R1");
    end
    ins(32'h3000_0000, 12, 32'h9_9999, 8'd5, "R4");
    lk(32'h3000_0123, 8'd5, "R4");
    // R5: lookup on the pointed slot moves the pointer past it
    lk(32'h1000_1000, 8'd2, "R5");
    ins(32'h3100_0000, 12, 32'h9_1111, 8'd5, "R5");
    lk(32'h3100_0fff, 8'd5, "R5");
    // R2: overlapping large and small pages, lowest index wins
    ins(32'h2000_0000, 16, 32'h0_0aaa, 8'd3, "R2");
    ins(32'h2000_5000, 12, 32'h0_bbbb, 8'd3, "R2");
    lk(32'h2000_5123, 8'd3, "R2");
    lk(32'h2000_6123, 8'd3, "R2");
    // R7: clear by tag
    inv(3'd2, 32'hdead_0000, 8'd1, "R7");
    for (int i = 0; i < N; i++) lk(32'h1000_0000 + i * 32'h1000, 8'(i % 2 + 1), "R7");
    // R8: clear by address, any tag
    inv(3'd3, 32'h2000_5555, 8'd99, "R8");
    lk(32'h2000_5123, 8'd3, "R8");
    lk(32'h3100_0000, 8'd5, "R8");
    // R9: same address under two tags, twice under one
    ins(32'h5000_0000, 12, 32'h1_0001, 8'd7, "R9");
    ins(32'h5000_0000, 12, 32'h1_0002, 8'd8, "R9");
    ins(32'h5000_0800, 12, 32'h1_0003, 8'd7, "R9");
    inv(3'd4, 32'h5000_0010, 8'd7, "R9");
    lk(32'h5000_0010, 8'd7, "R9");
    lk(32'h5000_0010, 8'd8, "R9");
    // R10: lookup during a command sees old state; insert with command is dropped
    idle_in(); inv_cmd = 3'd3; inv_va = 32'h5000_0000;
    lk_en = 1; lk_va = 32'h5000_0000; lk_ctx = 8'd8;
    set_ins(32'h6000_0000, 12, 32'h2_2222, 8'd9); cyc("R10");
    lk(32'h5000_0000, 8'd8, "R10");
    lk(32'h6000_0000, 8'd9, "R10");
    ins(32'h6000_0000, 12, 32'h2_2222, 8'd9, "R10");
    inv(3'd5, 32'h6000_0000, 8'd9, "R10");
    inv(3'd7, 32'h6000_0000, 8'd9, "R10");
    lk(32'h6000_0000, 8'd9, "R10");
    // R6: clear all, pointer back to slot 0
    inv(3'd1, 32'h0, 8'd0, "R6");
    lk(32'h6000_0000, 8'd9, "R6");
    ins(32'h7000_0000, 16, 32'h0_0777, 8'd4, "R6");
    lk(32'h7000_abcd, 8'd4, "R6");
    // lookup disabled gives zero outputs
    idle_in(); lk_va = 32'h7000_abcd; lk_ctx = 8'd4; cyc("R11");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [VA_W-1:0] va;
      int r;
      idle_in();
      r = int'($urandom % 100);
      va = 32'h4000_0000 + ($urandom % 6) * 32'h1_0000 + ($urandom & 32'hffff);
      lk_en = ($urandom % 4) != 0;
      lk_va = 32'h4000_0000 + ($urandom % 6) * 32'h1_0000 + ($urandom & 32'hffff);
      lk_ctx = 8'($urandom % 3 + 1);
      if (r < 35) set_ins(va, ($urandom % 2) ? 16 : 12, PA_W'($urandom & 32'hf_ffff), 8'($urandom % 3 + 1));
      if (r >= 25 && r < 40) begin
        inv_cmd = 3'($urandom % 8); inv_va = va; inv_asid = 8'($urandom % 3 + 1);
      end
      cyc("R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule